// File: doc/BRIEF.md
# Access Latency Cache Model

This block is a tag-only, fully associative cache whose only output is a latency figure for each memory access. It holds eight 64-byte lines (512 bytes), keeps no data, and replaces with true least-recently-used order. A timing model presents one access per cycle: an address and a flag that marks the access as a store or a load. One cycle later the block returns the latency that access would see, a hit flag, and running hit and miss totals.

Loads that hit cost 2 cycles and loads that miss cost 20. Stores always cost 1 cycle, but they still take part in replacement: a store hit refreshes its line, and a store miss allocates a line. Every miss fills its line at once. There is no fill delay, no outstanding-miss tracking, no dirty state and no writeback.

Top module: `lat_cache`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `rsp_valid_o` is 0 and both counters read 0. Reset invalidates every line, so the first access to any block after reset is a miss.
- R2: A load (`req_store_i`=0) that hits returns `rsp_lat_o` = 2.
- R3: A load that misses returns `rsp_lat_o` = 20.
- R4: A store (`req_store_i`=1) returns `rsp_lat_o` = 1, whether it hits or misses.
- R5: Any miss, load or store, installs its block immediately. A later access to any address with the same `addr[31:6]` hits, unless the block has been evicted in between.
- R6: Empty lines are filled before any valid line is evicted. The first 8 distinct blocks after reset all stay resident.
- R7: When all lines are valid, a miss evicts the block that was accessed least recently. Both hits and misses, loads and stores, make the accessed block the most recent.
- R8: An access sampled at a rising edge produces `rsp_valid_o`=1 in the following cycle. A cycle with no request produces `rsp_valid_o`=0 in the following cycle.
- R9: `rsp_hit_o` is 1 exactly when the access found its block resident.
- R10: `hit_cnt_o` and `miss_cnt_o` count hits and misses of all accesses since reset. Each updated count appears in the same cycle as the response, and the counters wrap at 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | An access is presented this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | 32 | Byte address; bits 31:6 form the block tag |
| rsp_valid_o | output | 1 | Response for the previous cycle's access |
| rsp_hit_o | output | 1 | The previous access hit |
| rsp_lat_o | output | 5 | Latency in cycles: 1, 2 or 20 |
| hit_cnt_o | output | 16 | Hits since reset |
| miss_cnt_o | output | 16 | Misses since reset |

## Verification
A corrupted recency order shows up only when the cache is full and a miss picks its victim. The wrong block is then dropped, and the first return to that block, or to the one that should have gone, reports a hit or miss flag and a latency that do not match. Depending on the traffic, that can be many accesses after the fault. A lost valid bit or a duplicated tag shows up at the next access to that block, as an unexpected miss or as counters that drift apart. The bench therefore fills the cache, reorders recency on purpose, and runs a long random stream over a pool of blocks slightly larger than the capacity, so that eviction decisions are exercised constantly.

// File: rtl/lat_cache_pkg.sv
package lat_cache_pkg;
  localparam int unsigned LAT_W = 5;
  localparam int unsigned CNT_W = 16;

  typedef enum logic [1:0] {
    ACC_LD_HIT,
    ACC_LD_MISS,
    ACC_ST
  } acc_kind_e;
endpackage

// File: rtl/lat_tag_cmp.sv
module lat_tag_cmp #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned TAG_W = 26,
  localparam int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           probe_i,
  output logic                       hit_o,
  output logic [IDX_W-1:0]           hit_idx_o
);
  logic [WAYS-1:0] hit_vec;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (tag_i[g] == probe_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (hit_vec[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;

  // R5
  tag_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/lat_lru_age.sv
module lat_lru_age #(
  parameter int unsigned WAYS = 8,
  localparam int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WAYS-1:0]  valid_i,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_idx_o
);
  logic [WAYS-1:0][IDX_W-1:0] age_q, age_d;
  logic [WAYS-1:0]            age_zero;
  logic                       free_found;

  // ages form a permutation of 0..WAYS-1; 0 is most recent
  always_comb begin
    age_d = age_q;
    if (touch_i) begin
      for (int i = 0; i < WAYS; i++) begin
        if (IDX_W'(i) == touch_idx_i)           age_d[i] = '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= IDX_W'(i);
    end else begin
      age_q <= age_d;
    end
  end

  // lowest empty line first, otherwise the oldest line
  always_comb begin
    victim_idx_o = '0;
    free_found   = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!free_found && !valid_i[i]) begin
        victim_idx_o = IDX_W'(i);
        free_found   = 1'b1;
      end
    end
    if (!free_found) begin
      for (int i = 0; i < WAYS; i++) begin
        if (age_q[i] == IDX_W'(WAYS - 1)) victim_idx_o = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_zero
    assign age_zero[g] = (age_q[g] == '0);
  end

  // R7
  age_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(age_zero) == 1);

  // R7
  touch_mru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/lat_cache.sv
module lat_cache
  import lat_cache_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BLK_BYTES   = 64,
  parameter int unsigned WAYS        = 8,
  parameter int unsigned LAT_LD_HIT  = 2,
  parameter int unsigned LAT_LD_MISS = 20,
  parameter int unsigned LAT_ST      = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [LAT_W-1:0]  rsp_lat_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int unsigned OFF_W = $clog2(BLK_BYTES);
  localparam int unsigned TAG_W = ADDR_W - OFF_W;
  localparam int unsigned IDX_W = $clog2(WAYS);

  logic [WAYS-1:0][TAG_W-1:0] tag_q;
  logic [WAYS-1:0]            valid_q;
  logic [TAG_W-1:0]           probe;
  logic                       hit;
  logic [IDX_W-1:0]           hit_idx, victim_idx, way;
  acc_kind_e                  kind;
  logic [LAT_W-1:0]           lat;

  assign probe = req_addr_i[ADDR_W-1:OFF_W];

  lat_tag_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tag_i     (tag_q),
    .valid_i   (valid_q),
    .probe_i   (probe),
    .hit_o     (hit),
    .hit_idx_o (hit_idx)
  );

  assign way = hit ? hit_idx : victim_idx;

  lat_lru_age #(.WAYS(WAYS)) u_lru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_q),
    .touch_i      (req_valid_i),
    .touch_idx_i  (way),
    .victim_idx_o (victim_idx)
  );

  always_comb begin
    if (req_store_i) kind = ACC_ST;
    else if (hit)    kind = ACC_LD_HIT;
    else             kind = ACC_LD_MISS;
    unique case (kind)
      ACC_ST:      lat = LAT_W'(LAT_ST);
      ACC_LD_HIT:  lat = LAT_W'(LAT_LD_HIT);
      default:     lat = LAT_W'(LAT_LD_MISS);
    endcase
  end

  // tag store: install on miss, no fill delay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q   <= '0;
      valid_q <= '0;
    end else if (req_valid_i && !hit) begin
      tag_q[way]   <= probe;
      valid_q[way] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_lat_o   <= '0;
      hit_cnt_o   <= '0;
      miss_cnt_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_hit_o <= hit;
        rsp_lat_o <= lat;
        if (hit) hit_cnt_o  <= hit_cnt_o + 1'b1;
        else     miss_cnt_o <= miss_cnt_o + 1'b1;
      end
    end
  end

  // R8
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R8
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  // R4
  store_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i) |=> rsp_lat_o == LAT_W'(LAT_ST));

  // R2
  load_hit_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_store_i) |=> (!rsp_hit_o || rsp_lat_o == LAT_W'(LAT_LD_HIT)));

  // R3
  load_miss_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_store_i) |=> (rsp_hit_o || rsp_lat_o == LAT_W'(LAT_LD_MISS)));

  // R10
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> CNT_W'(hit_cnt_o + miss_cnt_o) ==
                    CNT_W'($past(hit_cnt_o) + $past(miss_cnt_o) + 1'b1));

  // R5
  miss_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit) |=> $countones(valid_q) >= 1);
endmodule

// File: tb/lat_cache_bench.sv
`timescale 1ns/1ps
module lat_cache_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_store_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        rsp_valid_o, rsp_hit_o;
  logic [4:0]  rsp_lat_o;
  logic [15:0] hit_cnt_o, miss_cnt_o;

  lat_cache u_lat_cache (
    .clk_i, .rst_ni, .req_valid_i, .req_store_i, .req_addr_i,
    .rsp_valid_o, .rsp_hit_o, .rsp_lat_o, .hit_cnt_o, .miss_cnt_o
  );

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // recency list model: index 0 most recent
  logic [25:0] mru [8];
  int          fill = 0;
  int          m_hits = 0, m_miss = 0;

  function automatic void model_clear();
    fill = 0; m_hits = 0; m_miss = 0;
  endfunction

  function automatic bit model_access(input logic [25:0] t);
    int pos = -1;
    for (int i = 0; i < fill; i++) if (mru[i] == t) pos = i;
    if (pos < 0) begin
      if (fill < 8) fill++;
      pos = fill - 1;
      for (int i = pos; i > 0; i--) mru[i] = mru[i-1];
      mru[0] = t;
      return 1'b0;
    end
    for (int i = pos; i > 0; i--) mru[i] = mru[i-1];
    mru[0] = t;
    return 1'b1;
  endfunction

  function automatic int exp_lat(input bit st, input bit h);
    return st ? 1 : (h ? 2 : 20);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic acc(input bit st, input logic [31:0] a, input string req);
    bit eh;
    eh = model_access(a[31:6]);
    if (eh) m_hits++; else m_miss++;
    req_valid_i = 1'b1; req_store_i = st; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    n_chk++;
    if (rsp_valid_o !== 1'b1 || rsp_hit_o !== eh ||
        rsp_lat_o !== 5'(exp_lat(st, eh)) ||
        hit_cnt_o !== 16'(m_hits) || miss_cnt_o !== 16'(m_miss)) begin
      n_fail++;
      $display("FAIL %s/R8/R9/R10 addr=%h actual v=%0d hit=%0d lat=%0d h=%0d m=%0d expected v=1 hit=%0d lat=%0d h=%0d m=%0d",
               req, a, rsp_valid_o, rsp_hit_o, rsp_lat_o, hit_cnt_o, miss_cnt_o,
               eh, exp_lat(st, eh), m_hits, m_miss);
    end
  endtask

  task automatic idle_check();
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check("R8 idle", rsp_valid_o, 0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_clear();
    @(negedge clk_i);
    check("R1 valid in reset", rsp_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid", rsp_valid_o, 0);
    check("R1 hit_cnt", hit_cnt_o, 0);
    check("R1 miss_cnt", miss_cnt_o, 0);
  endtask

  function automatic logic [31:0] blk(input int n, input int off);
    return {26'(32'h0040_0000 + n * 7), 6'(off)};
  endfunction

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R6 / R3: eight cold load misses fill empty lines
    for (int i = 0; i < 8; i++) acc(1'b0, blk(i, i), "R3/R6 cold");
    // R6 / R2: all eight still resident
    for (int i = 0; i < 8; i++) acc(1'b0, blk(i, 63 - i), "R2/R6 resident");
    idle_check();
    // R7: refresh block 0, new block evicts block 1
    acc(1'b0, blk(0, 5), "R7 refresh");
    acc(1'b0, blk(8, 0), "R7 new");
    acc(1'b0, blk(1, 0), "R7 evicted");
    acc(1'b0, blk(0, 9), "R7 kept");
    // R4 / R5: store miss allocates, load then hits
    acc(1'b1, blk(20, 3), "R4 store miss");
    acc(1'b0, blk(20, 60), "R5 after store");
    acc(1'b1, blk(20, 1), "R4 store hit");
    // R1: reset clears contents and counters
    do_reset();
    acc(1'b0, blk(20, 0), "R1 after reset");
    // random stream over 11 blocks
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(9) == 0) idle_check();
      else acc(1'($urandom_range(3) == 0), blk($urandom_range(10), $urandom_range(63)), "R7 random");
    end
    finish_up();
  end
endmodule